// File: doc/BRIEF.md
# Program Counter and Call/Return Sequencer

This block owns the 20-bit instruction pointer of a processor core together with its stack pointer. Each cycle it can accept one control operation from the decoder: step forward by the length of the current instruction, jump to an absolute target, jump by a signed offset, call a subroutine, or return from one. Every operation comes in two widths. The short (word) form works on the low 16 bits and leaves the top four bits zero. The long (address) form works on all 20 bits, so any location in a 1 MB space can be reached.

Calls push the return address through a simple 16-bit memory port, and returns pop it back. A short call stores one word. A long call stores two words, with the upper nibble at the lower address. While these transfers run, the block raises `busy`, holds the program counter and ignores new requests. The decoder keeps its request asserted until it is accepted. A synchronous reset loads the program counter and the stack pointer from two input vectors.

Top module: `pc_call_unit`

## Requirements
- R1: After a synchronous reset, `pc` equals `rstVector` and `sp` equals `rstStack`, each with bit 0 forced to zero. Bit 0 of `pc` and of `sp` is zero in every cycle.
- R2: An accepted advance (`opKind`=0) adds (`opLen`+1)*2 bytes to `pc` (2, 4, 6 or 8), modulo 2^20, on the next clock edge.
- R3: An accepted short jump (`opKind`=1, `opLong`=0) loads `opTarget[15:1]` into `pc[15:1]` and clears `pc[19:16]`.
- R4: An accepted long jump (`opKind`=1, `opLong`=1) loads `opTarget[19:1]` into `pc[19:1]`.
- R5: An accepted relative jump (`opKind`=2) adds `opTarget` to `pc`. The long form adds over all 20 bits. The short form adds the low 16 bits, wraps within them and clears `pc[19:16]`. Bit 0 of the result is cleared.
- R6: An accepted short call (`opKind`=3, `opLong`=0) writes the low 16 bits of `pc`+length to address `sp`-2 in the following cycle. At the end of that cycle `sp` drops by 2 and `pc` takes the short target, as in R3.
- R7: An accepted long call writes `{12'b0, ret[19:16]}` to `sp`-4 and then `ret[15:0]` to `sp`-2 in two successive cycles. Here ret is `pc`+length. At the end of the second cycle `sp` drops by 4 and `pc` takes the 20-bit target.
- R8: An accepted short return (`opKind`=4, `opLong`=0) reads one word at `sp`. `pc` becomes `{4'b0, word[15:1], 1'b0}` and `sp` rises by 2.
- R9: An accepted long return reads `sp` and then `sp`+2 in two successive cycles. `pc` becomes `{first[3:0], second[15:1], 1'b0}` and `sp` rises by 4.
- R10: A request is accepted only when `opValid` is high and `busy` is low. While `busy` is high, requests have no effect and `pc` and `sp` hold. `opKind` values 5 to 7 have no effect.
- R11: `memReq` is high only in busy cycles. `memWe` is high for pushes and low for pops. `memRdata` is sampled at the clock edge that ends a read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rstVector | input | 20 | Program counter value loaded at reset |
| rstStack | input | 20 | Stack pointer value loaded at reset |
| opValid | input | 1 | Operation request |
| opKind | input | 3 | 0 advance, 1 jump, 2 relative jump, 3 call, 4 return |
| opLong | input | 1 | 1 selects the 20-bit form, 0 the 16-bit form |
| opLen | input | 2 | Instruction length code, length = (code+1)*2 bytes |
| opTarget | input | 20 | Jump or call target, or offset for a relative jump |
| busy | output | 1 | A stack transfer is in progress |
| pc | output | 20 | Program counter |
| sp | output | 20 | Stack pointer |
| memReq | output | 1 | Stack memory access this cycle |
| memWe | output | 1 | Access is a write |
| memAddr | output | 20 | Byte address of the stack word |
| memWdata | output | 16 | Data to write |
| memRdata | input | 16 | Data read from the stack word |

## Verification
A new request and the last stack transfer of a call or return can fall in the same cycle. The bench provokes this by presenting the next operation right after a call or return is accepted and holding it through every busy cycle. It also pulses a one-cycle jump in the middle of a transfer and drops it again. The judgement is that the held request takes effect only in the first cycle after `busy` falls, starting from the program counter the call or return produced, and that the pulsed jump leaves no trace. A reset that arrives in the middle of a long call is also checked: it must abandon the transfer and leave the reset vectors in place.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [2:0] {
    OP_ADV  = 3'd0,
    OP_JUMP = 3'd1,
    OP_JADD = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4
  } pcuOp_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_POP_HI,
    ST_POP_LO
  } pcuState_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic advance;   // sequential step
    logic jump;      // absolute jump
    logic jadd;      // relative jump
    logic capture;   // latch return address and call target
    logic memReq;    // stack access this cycle
    logic memWe;     // access is a push
    logic hiWord;    // access concerns the upper-nibble word
    logic wide;      // 20-bit form
    logic popHi;     // latch upper nibble from read data
    logic callDone;  // commit call: load target, lower SP
    logic retDone;   // commit return: load popped PC, raise SP
  } pcuStrobe_t;

endpackage

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
  import pcu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       opValid,
  input  logic [2:0] opKind,
  input  logic       opLong,
  output pcuStrobe_t strb,
  output logic       busy
);

  pcuState_e state, stateNext;
  logic      wideQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      wideQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && opValid) wideQ <= opLong;
    end
  end

  always_comb begin
    strb      = '0;
    stateNext = state;
    strb.wide = (state == ST_IDLE) ? opLong : wideQ;
    unique case (state)
      ST_IDLE: begin
        if (opValid) begin
          case (pcuOp_e'(opKind))
            OP_ADV:  strb.advance = 1'b1;
            OP_JUMP: strb.jump    = 1'b1;
            OP_JADD: strb.jadd    = 1'b1;
            OP_CALL: begin
              strb.capture = 1'b1;
              stateNext    = opLong ? ST_PUSH_HI : ST_PUSH_LO;
            end
            OP_RET:  stateNext = opLong ? ST_POP_HI : ST_POP_LO;
            default: stateNext = ST_IDLE;
          endcase
        end
      end
      ST_PUSH_HI: begin
        strb.memReq = 1'b1;
        strb.memWe  = 1'b1;
        strb.hiWord = 1'b1;
        stateNext   = ST_PUSH_LO;
      end
      ST_PUSH_LO: begin
        strb.memReq   = 1'b1;
        strb.memWe    = 1'b1;
        strb.callDone = 1'b1;
        stateNext     = ST_IDLE;
      end
      ST_POP_HI: begin
        strb.memReq = 1'b1;
        strb.hiWord = 1'b1;
        strb.popHi  = 1'b1;
        stateNext   = ST_POP_LO;
      end
      ST_POP_LO: begin
        strb.memReq  = 1'b1;
        strb.retDone = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/pcu_datapath.sv
module pcu_datapath
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int WORD_W = 16,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rstVector,
  input  logic [ADDR_W-1:0] rstStack,
  input  logic [LEN_W-1:0]  opLen,
  input  logic [ADDR_W-1:0] opTarget,
  input  pcuStrobe_t        strb,
  input  logic [WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata
);

  localparam int HI_W = ADDR_W - WORD_W;
  localparam logic [ADDR_W-1:0] STEP_NARROW = ADDR_W'(WORD_W / 8);
  localparam logic [ADDR_W-1:0] STEP_WIDE   = ADDR_W'(2 * (WORD_W / 8));

  logic [ADDR_W-1:0] retAddr, tgtReg;
  logic [HI_W-1:0]   hiNib;
  logic [ADDR_W-1:0] lenBytes, seqPc, jumpPc, addPc, retPc, spStep;
  logic [WORD_W-1:0] sumNarrow;

  function automatic logic [ADDR_W-1:0] evenAlign(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:1], 1'b0};
  endfunction

  function automatic logic [ADDR_W-1:0] narrowPc(input logic [WORD_W-1:0] w);
    return {{HI_W{1'b0}}, w[WORD_W-1:1], 1'b0};
  endfunction

  // Instruction length in bytes: (code + 1) * 2
  assign lenBytes  = ADDR_W'({opLen, 1'b0}) + ADDR_W'(2);
  assign seqPc     = pc + lenBytes;
  assign jumpPc    = strb.wide ? evenAlign(opTarget) : narrowPc(opTarget[WORD_W-1:0]);
  assign sumNarrow = pc[WORD_W-1:0] + opTarget[WORD_W-1:0];
  assign addPc     = strb.wide ? evenAlign(pc + opTarget) : narrowPc(sumNarrow);
  assign retPc     = strb.wide ? {hiNib, memRdata[WORD_W-1:1], 1'b0}
                               : narrowPc(memRdata);
  assign spStep    = strb.wide ? STEP_WIDE : STEP_NARROW;

  // Stack addressing: upper word at the lower address
  always_comb begin
    if (strb.memWe)
      memAddr = strb.hiWord ? (sp - STEP_WIDE) : (sp - STEP_NARROW);
    else if (strb.hiWord || !strb.wide)
      memAddr = sp;
    else
      memAddr = sp + STEP_NARROW;
  end

  assign memWdata = strb.hiWord ? WORD_W'(retAddr[ADDR_W-1:WORD_W])
                                : retAddr[WORD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= evenAlign(rstVector);
      sp      <= evenAlign(rstStack);
      retAddr <= '0;
      tgtReg  <= '0;
      hiNib   <= '0;
    end else begin
      if (strb.advance) pc <= seqPc;
      if (strb.jump)    pc <= jumpPc;
      if (strb.jadd)    pc <= addPc;
      if (strb.capture) begin
        retAddr <= seqPc;
        tgtReg  <= jumpPc;
      end
      if (strb.popHi) hiNib <= memRdata[HI_W-1:0];
      if (strb.callDone) begin
        pc <= tgtReg;
        sp <= sp - spStep;
      end
      if (strb.retDone) begin
        pc <= retPc;
        sp <= sp + spStep;
      end
    end
  end

endmodule

// File: rtl/pc_call_unit.sv
module pc_call_unit
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int WORD_W = 16,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rstVector,
  input  logic [ADDR_W-1:0] rstStack,
  input  logic              opValid,
  input  logic [2:0]        opKind,
  input  logic              opLong,
  input  logic [LEN_W-1:0]  opLen,
  input  logic [ADDR_W-1:0] opTarget,
  output logic              busy,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata
);

  pcuStrobe_t strb;

  pcu_ctrl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .opValid (opValid),
    .opKind  (opKind),
    .opLong  (opLong),
    .strb    (strb),
    .busy    (busy)
  );

  pcu_datapath #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .LEN_W  (LEN_W)
  ) uPath (
    .clk       (clk),
    .rst       (rst),
    .rstVector (rstVector),
    .rstStack  (rstStack),
    .opLen     (opLen),
    .opTarget  (opTarget),
    .strb      (strb),
    .memRdata  (memRdata),
    .pc        (pc),
    .sp        (sp),
    .memAddr   (memAddr),
    .memWdata  (memWdata)
  );

  assign memReq = strb.memReq;
  assign memWe  = strb.memWe;

endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int ADDR_W = 20,
  parameter int WORD_W = 16,
  parameter int LEN_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              opValid,
  input logic [2:0]        opKind,
  input logic              opLong,
  input logic [LEN_W-1:0]  opLen,
  input logic              busy,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] sp,
  input logic              memReq,
  input logic              memWe
);

  AST_PC_EVEN: assert property (@(posedge clk) disable iff (rst) !pc[0]); // R1
  AST_SP_EVEN: assert property (@(posedge clk) disable iff (rst) !sp[0]); // R1

  AST_ADVANCE_STEP: assert property (@(posedge clk) disable iff (rst)
    (opValid && !busy && opKind == 3'd0) |=>
      pc == $past(pc) + ADDR_W'({$past(opLen), 1'b0}) + ADDR_W'(2)); // R2

  AST_SHORT_JUMP_TOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (opValid && !busy && opKind == 3'd1 && !opLong) |=>
      pc[ADDR_W-1:WORD_W] == '0); // R3

  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy |-> $stable(pc)); // R10

  AST_SP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy |-> $stable(sp)); // R10

  AST_MEM_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    memReq |-> busy); // R11

  AST_WE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    memWe |-> memReq); // R11

endmodule

bind pc_call_unit pcu_checker #(
  .ADDR_W (ADDR_W),
  .WORD_W (WORD_W),
  .LEN_W  (LEN_W)
) uChk (
  .clk     (clk),
  .rst     (rst),
  .opValid (opValid),
  .opKind  (opKind),
  .opLong  (opLong),
  .opLen   (opLen),
  .busy    (busy),
  .pc      (pc),
  .sp      (sp),
  .memReq  (memReq),
  .memWe   (memWe)
);

// File: tb/sim_pc_call_unit.sv
`timescale 1ns/1ps
module sim_pc_call_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] rstVector = 20'h12345;
  logic [19:0] rstStack  = 20'h00801;
  logic        opValid = 1'b0;
  logic [2:0]  opKind = 3'd0;
  logic        opLong = 1'b0;
  logic [1:0]  opLen = 2'd0;
  logic [19:0] opTarget = 20'h0;
  logic        busy, memReq, memWe;
  logic [19:0] pc, sp, memAddr;
  logic [15:0] memWdata, memRdata;

  logic [15:0] ram [0:2047];

  always #4 clk = ~clk;

  assign memRdata = ram[memAddr[11:1]];

  pc_call_unit u0 (
    .clk(clk), .rst(rst), .rstVector(rstVector), .rstStack(rstStack),
    .opValid(opValid), .opKind(opKind), .opLong(opLong), .opLen(opLen),
    .opTarget(opTarget), .busy(busy), .pc(pc), .sp(sp), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata)
  );

  // Behavioural reference model
  typedef struct { bit we; int addr; int data; } txn_t;
  txn_t q[$];
  int   mPc, mSp, pendPc, pendSp;
  bit   accepted;
  int   checks = 0, fails = 0;
  string curReq = "R1";

  function automatic int idx(int a);
    return (a >> 1) & 2047;
  endfunction

  always @(posedge clk) begin
    int len, ret, tgt;
    txn_t t;
    accepted = 1'b0;
    if (rst) begin
      q.delete();
      mPc = int'(rstVector) & 32'hFFFFE;
      mSp = int'(rstStack) & 32'hFFFFE;
    end else if (q.size() != 0) begin
      t = q.pop_front();
      if (t.we) ram[idx(t.addr)] = t.data[15:0];
      if (q.size() == 0) begin
        mPc = pendPc;
        mSp = pendSp;
      end
    end else if (opValid) begin
      accepted = 1'b1;
      len = 2 * (int'(opLen) + 1);
      tgt = opLong ? (int'(opTarget) & 32'hFFFFE) : (int'(opTarget) & 32'hFFFE);
      case (opKind)
        3'd0: mPc = (mPc + len) & 32'hFFFFF;
        3'd1: mPc = tgt;
        3'd2: mPc = opLong ? ((mPc + int'(opTarget)) & 32'hFFFFE)
                           : ((mPc + int'(opTarget)) & 32'hFFFE);
        3'd3: begin
          ret = (mPc + len) & 32'hFFFFF;
          pendPc = tgt;
          if (opLong) begin
            q.push_back('{1'b1, mSp - 4, ret >> 16});
            q.push_back('{1'b1, mSp - 2, ret & 32'hFFFF});
            pendSp = mSp - 4;
          end else begin
            q.push_back('{1'b1, mSp - 2, ret & 32'hFFFF});
            pendSp = mSp - 2;
          end
        end
        3'd4: begin
          if (opLong) begin
            q.push_back('{1'b0, mSp, 0});
            q.push_back('{1'b0, mSp + 2, 0});
            pendPc = ((int'(ram[idx(mSp)]) & 32'hF) << 16) |
                     (int'(ram[idx(mSp + 2)]) & 32'hFFFE);
            pendSp = mSp + 4;
          end else begin
            q.push_back('{1'b0, mSp, 0});
            pendPc = int'(ram[idx(mSp)]) & 32'hFFFE;
            pendSp = mSp + 2;
          end
        end
        default: ;
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %05h expected %05h", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    bit expReq;
    expReq = (q.size() != 0);
    check(int'(pc) == mPc, curReq, "pc", int'(pc), mPc);
    check(int'(sp) == mSp, curReq, "sp", int'(sp), mSp);
    check(busy == expReq, "R10", "busy", int'(busy), int'(expReq));
    check(memReq == expReq, "R11", "memReq", int'(memReq), int'(expReq));
    if (expReq) begin
      check(memWe == q[0].we, "R11", "memWe", int'(memWe), int'(q[0].we));
      check(int'(memAddr) == q[0].addr, curReq, "memAddr", int'(memAddr), q[0].addr);
      if (q[0].we)
        check(int'(memWdata) == q[0].data, curReq, "memWdata", int'(memWdata), q[0].data);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    compareAll();
  endtask

  // Present an operation and hold it until accepted
  task automatic doOp(input int kind, input bit lng, input int len,
                      input int tgt, input string req);
    curReq   = req;
    opKind   = kind[2:0];
    opLong   = lng;
    opLen    = len[1:0];
    opTarget = tgt[19:0];
    opValid  = 1'b1;
    do tick(); while (!accepted);
    opValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (q.size() != 0) tick();
    tick();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) ram[i] = 16'(i * 16'h1357) ^ 16'hA5A4;
    curReq = "R1";
    repeat (3) tick();
    #2 rst = 1'b0;
    tick();
    // R1: reset values with bit 0 cleared
    check(pc == 20'h12344, "R1", "reset pc", int'(pc), 32'h12344);
    check(sp == 20'h00800, "R1", "reset sp", int'(sp), 32'h00800);

    // R2: all four lengths
    for (int l = 0; l < 4; l++) doOp(0, 0, l, 0, "R2");
    // R4 then R2 wrap at 20 bits
    doOp(1, 1, 0, 32'hFFFFE, "R4");
    doOp(0, 0, 1, 0, "R2");
    check(pc == 20'h00002, "R2", "wrap", int'(pc), 2);
    // R3: short jump clears upper bits
    doOp(1, 1, 0, 32'hABCDF, "R4");
    check(pc == 20'hABCDE, "R4", "long jump", int'(pc), 32'hABCDE);
    doOp(1, 0, 0, 32'hABCDF, "R3");
    check(pc == 20'h0BCDE, "R3", "short jump", int'(pc), 32'h0BCDE);
    // R5: relative jumps
    doOp(1, 1, 0, 32'h1FFFC, "R4");
    doOp(2, 1, 0, 4, "R5");
    check(pc == 20'h20000, "R5", "long add", int'(pc), 32'h20000);
    doOp(1, 1, 0, 32'h1FFFC, "R4");
    doOp(2, 0, 0, 8, "R5");
    check(pc == 20'h00004, "R5", "short add wrap", int'(pc), 4);
    doOp(1, 1, 0, 32'h3A000, "R4");
    doOp(2, 1, 0, 32'hFFFF0, "R5");
    // R7 long call, R6 nested short call, returns in reverse
    doOp(3, 1, 1, 32'h5F010, "R7");
    waitIdle();
    check(sp == 20'h007FC, "R7", "sp after long call", int'(sp), 32'h007FC);
    doOp(3, 0, 3, 32'h7C123, "R6");
    waitIdle();
    check(pc == 20'h0C122, "R6", "short call target", int'(pc), 32'h0C122);
    doOp(4, 0, 0, 0, "R8");
    waitIdle();
    check(sp == 20'h007FC, "R8", "sp after short ret", int'(sp), 32'h007FC);
    doOp(4, 1, 0, 0, "R9");
    waitIdle();
    check(pc == 20'h39FF4, "R9", "long ret pc", int'(pc), 32'h39FF4);
    check(sp == 20'h00800, "R9", "sp after long ret", int'(sp), 32'h00800);

    // R10: next request held through busy cycles
    doOp(3, 1, 0, 32'h4A002, "R7");
    doOp(0, 0, 2, 0, "R10");
    doOp(3, 0, 0, 32'h12346, "R6");
    doOp(4, 0, 1, 0, "R10");
    doOp(4, 1, 0, 0, "R9");
    // R10: one-cycle jump inside a transfer is dropped
    doOp(3, 1, 0, 32'h60000, "R10");
    opKind = 3'd1; opLong = 1'b1; opTarget = 20'h77776; opValid = 1'b1;
    tick();
    opValid = 1'b0;
    waitIdle();
    check(pc == 20'h60000, "R10", "pulse ignored", int'(pc), 32'h60000);
    // R10: unused kinds have no effect
    curReq = "R10";
    opKind = 3'd6; opValid = 1'b1;
    repeat (3) tick();
    opKind = 3'd7;
    repeat (2) tick();
    opValid = 1'b0;
    check(pc == 20'h60000, "R10", "kind 6/7 ignored", int'(pc), 32'h60000);
    doOp(4, 1, 0, 0, "R9");
    waitIdle();

    // R1: reset in the middle of a long call
    doOp(3, 1, 0, 32'h11110, "R1");
    curReq = "R1";
    rst = 1'b1;
    repeat (2) tick();
    rst = 1'b0;
    repeat (2) tick();
    check(pc == 20'h12344, "R1", "reset mid-call pc", int'(pc), 32'h12344);
    check(sp == 20'h00800, "R1", "reset mid-call sp", int'(sp), 32'h00800);

    summary();
    $finish;
  end

endmodule